// File: doc/BRIEF.md
# Bit-Serial 32/64 ARX Block Cipher Engine

This block encrypts one 32-bit block under a 64-bit key with the Speck32/64 add-rotate-XOR cipher. The datapath works on one bit per clock. A single full adder with a carry flip-flop forms each modular word sum, least significant bit first. Rotations come from the register positions that feed the adder and the XOR, so there is no barrel rotator. The round-key schedule uses a second copy of the same serial round lane. That lane runs in lockstep with the data lane and produces each round-key bit in the same cycle that the data adder consumes it.

The host puts a plaintext and a key on the parallel inputs and pulses `start`. In that accepting cycle the core loads both lanes. It then runs 22 rounds of 16 clocks each and, in a finish cycle, registers the ciphertext and raises `done` for one clock. Inputs are sampled only on the accepting edge. The ciphertext output holds its value until the next block completes.

The controller has three states:
- `ST_IDLE` waits for `start`.
- `ST_RUN` steps the bit and round counters.
- `ST_FIN` publishes the result.

The transitions are:
- idle to run when `start` is high.
- run to run on every bit except the last bit of round 21.
- run to finish on that last bit.
- finish to idle unconditionally.

Top module: `speck32_serial_enc`

## Requirements
- R1: While reset is asserted and after it is released, `done` is 0 and `ciphertext` is 0 until the first block completes.
- R2: With key = 64'h1918_1110_0908_0100 and plaintext = 32'h6574_694c, the ciphertext is 32'ha868_42f2.
- R3: The ciphertext equals Speck32/64 encryption for any inputs, with these field positions:
  - plaintext[31:16] is x and plaintext[15:0] is y, and the ciphertext uses the same layout.
  - key[15:0] is the first round key k0.
  - key[31:16], key[47:32] and key[63:48] are the schedule words l0, l1 and l2.
  - rotations are right by 7 and left by 2.
  - the schedule XORs the round index, counting from 0, into the new l word.
  - 22 rounds are applied.
- R4: `done` rises exactly 353 clock edges after the edge that accepts `start`, which is 22×16 round clocks plus one finish cycle.
- R5: `start` asserted in the run or finish state is ignored. Timing and the result of the block in flight do not change, and no extra block is started.
- R6: `plaintext` and `key` are sampled only on the accepting edge. Changing them during a run does not change the result.
- R7: `done` is high for exactly one cycle per block, and `ciphertext` changes only in a cycle where `done` is high.
- R8: With `start` held high, the next block is accepted on the first edge after the return to idle, and its `done` arrives 707 edges after the first accept.
- R9: Carries propagate across all 16 bits of each word sum and never leak from one word sum into the next. All-ones and carry-heavy inputs still match R3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a block when idle |
| plaintext | input | 32 | Block input, {x, y} |
| key | input | 64 | Key, {l2, l1, l0, k0} |
| ciphertext | output | 32 | Result, {x, y}, held between blocks |
| done | output | 1 | One-cycle pulse when ciphertext is updated |

## Verification
Carry-heavy operands target the carry clear at bit 0. A design that carries over from the previous word would be wrong on all-ones data and keys, although it might pass sparse vectors. The published vector and several unrelated vectors exercise the tap positions of the rotations and the order of the key queue. A wrong tap, an off-by-one in the split shift register, or a queue rotated the wrong way garbles every block.

Pulses on `start` during a run and during the finish cycle, together with input changes mid-run, check the busy guard and that inputs are captured only at the accepting edge. A design that restarts or re-samples would either miss the 353-edge `done` or return a different ciphertext. A held `start` checks the re-accept edge after finish, where an extra or missing idle cycle shifts the second `done`.

// File: rtl/speck_pkg.sv
package speck_pkg;
    localparam int WORD      = 16;
    localparam int ROT_R     = 7;
    localparam int ROT_L     = 2;
    localparam int ROUNDS    = 22;
    localparam int KEY_WORDS = 4;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_RUN,
        ST_FIN
    } ctl_state_t;
endpackage

// File: rtl/round_timer.sv
module round_timer #(
    parameter int W      = 16,
    parameter int ROUNDS = 22,
    localparam int BW    = $clog2(W),
    localparam int RW    = $clog2(ROUNDS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  logic          en,
    output logic [BW-1:0] bit_idx,
    output logic [RW-1:0] rnd,
    output logic          word_end,
    output logic          last_round
);
    localparam logic [BW-1:0] LAST_BIT = BW'(W - 1);
    localparam logic [RW-1:0] LAST_RND = RW'(ROUNDS - 1);

    assign word_end   = (bit_idx == LAST_BIT);
    assign last_round = (rnd == LAST_RND);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_idx <= '0;
            rnd     <= '0;
        end else if (clear) begin
            bit_idx <= '0;
            rnd     <= '0;
        end else if (en) begin
            if (word_end) begin
                bit_idx <= '0;
                rnd     <= last_round ? '0 : rnd + 1'b1;
            end else begin
                bit_idx <= bit_idx + 1'b1;
            end
        end
    end

    // R4: bit position advances by exactly one per running clock inside a word
    assert_bit_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !clear && !word_end) |=> (bit_idx == $past(bit_idx) + 1'b1));

    // R4: round index holds steady while a word is in progress
    assert_round_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !clear && !word_end) |=> (rnd == $past(rnd)));
endmodule

// File: rtl/arx_serial_lane.sv
module arx_serial_lane #(
    parameter int W  = 16,
    parameter int A  = 7,
    parameter int B  = 2,
    localparam int BW = $clog2(W)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic [BW-1:0] bit_idx,
    input  logic          kbit,
    input  logic          ld_x,
    input  logic [W-1:0]  ld_x_val,
    input  logic          ld_y,
    input  logic [W-1:0]  ld_y_val,
    output logic          y_bit,
    output logic [W-1:0]  x_word,
    output logic [W-1:0]  y_word,
    output logic [W-1:0]  x_next
);
    localparam logic [BW-1:0] A_IDX = BW'(A);
    localparam logic [BW-1:0] B_IDX = BW'(B);

    // x is kept in two chains: the upper chain starts at bit A so that its
    // bottom cell is the right-rotated operand bit for the current position
    logic [W-1:A] xh_q, xh_n;
    logic [A-1:0] xl_q, xl_n;
    logic [W-1:0] y_q;
    logic [B-1:0] lag_q;      // bits of y already shifted out, kept B deep
    logic         carry_q;

    logic x_tap, cin, sum_b, x_new, y_old, y_new, carry_n;

    always_comb begin
        x_tap   = xh_q[A];
        cin     = (bit_idx == '0) ? 1'b0 : carry_q;
        sum_b   = x_tap ^ y_q[0] ^ cin;
        carry_n = (x_tap & y_q[0]) | (x_tap & cin) | (y_q[0] & cin);
        x_new   = sum_b ^ kbit;
        // the first B positions read the not-yet-overwritten top of y,
        // later positions read the lag copy
        y_old   = (bit_idx < B_IDX) ? y_q[W-B] : lag_q[B-1];
        y_new   = y_old ^ x_new;
        if (bit_idx < A_IDX) begin
            xl_n = {x_new, xl_q[A-1:1]};
            xh_n = {xl_q[0], xh_q[W-1:A+1]};
        end else begin
            xl_n = xl_q;
            xh_n = {x_new, xh_q[W-1:A+1]};
        end
    end

    assign y_bit  = y_q[0];
    assign x_word = {xh_q, xl_q};
    assign y_word = y_q;
    assign x_next = {xh_n, xl_n};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            xh_q <= '0;
            xl_q <= '0;
        end else if (ld_x) begin
            xh_q <= ld_x_val[W-1:A];
            xl_q <= ld_x_val[A-1:0];
        end else if (en) begin
            xh_q <= xh_n;
            xl_q <= xl_n;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            y_q     <= '0;
            lag_q   <= '0;
            carry_q <= 1'b0;
        end else if (ld_y) begin
            y_q     <= ld_y_val;
            lag_q   <= '0;
            carry_q <= 1'b0;
        end else if (en) begin
            y_q     <= {y_new, y_q[W-1:1]};
            lag_q   <= {lag_q[B-2:0], y_q[0]};
            carry_q <= carry_n;
        end
    end

    // R6: a parallel load lands in the x word on the following cycle
    assert_load_x_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ld_x |=> (x_word == $past(ld_x_val)));

    // R6: a parallel load lands in the y word on the following cycle
    assert_load_y_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ld_y |=> (y_word == $past(ld_y_val)));

    // R5: the x word does not move while neither loading nor running
    assert_x_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!en && !ld_x) |=> $stable(x_word));
endmodule

// File: rtl/speck_key_sched.sv
module speck_key_sched #(
    parameter int W      = 16,
    parameter int A      = 7,
    parameter int B      = 2,
    parameter int M      = 4,
    parameter int ROUNDS = 22,
    localparam int BW    = $clog2(W),
    localparam int RW    = $clog2(ROUNDS)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           ld,
    input  logic [M*W-1:0] key,
    input  logic           en,
    input  logic [BW-1:0]  bit_idx,
    input  logic [RW-1:0]  rnd,
    input  logic           word_end,
    output logic           rk_bit
);
    localparam int QD = M - 2;   // schedule words waiting behind the front word

    logic [W-1:0] lq_q [QD];
    logic [W-1:0] rnd_ext;
    logic [W-1:0] front_ld_val;
    logic [W-1:0] front_next;
    logic [W-1:0] front_word;
    logic [W-1:0] k_word;
    logic         front_ld;
    logic         idx_bit;

    assign rnd_ext      = W'(rnd);
    assign idx_bit      = rnd_ext[bit_idx];
    assign front_ld     = ld | (en & word_end);
    assign front_ld_val = ld ? key[2*W-1:W] : lq_q[0];

    // front word plays x, the running round key plays y, the round index is the key
    arx_serial_lane #(.W(W), .A(A), .B(B)) u_lane (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (en),
        .bit_idx  (bit_idx),
        .kbit     (idx_bit),
        .ld_x     (front_ld),
        .ld_x_val (front_ld_val),
        .ld_y     (ld),
        .ld_y_val (key[W-1:0]),
        .y_bit    (rk_bit),
        .x_word   (front_word),
        .y_word   (k_word),
        .x_next   (front_next)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int j = 0; j < QD; j++) lq_q[j] <= '0;
        end else if (ld) begin
            for (int j = 0; j < QD; j++) lq_q[j] <= key[(j+2)*W +: W];
        end else if (en && word_end) begin
            for (int j = 0; j < QD - 1; j++) lq_q[j] <= lq_q[j+1];
            lq_q[QD-1] <= front_next;
        end
    end

    // R3: on a word boundary the old second queue entry becomes the front word
    assert_queue_advance_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (en && word_end && !ld) |=> (front_word == $past(lq_q[0])));

    // R3: the schedule queue is frozen inside a word
    assert_queue_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!ld && !(en && word_end)) |=> (lq_q[QD-1] == $past(lq_q[QD-1])));
endmodule

// File: rtl/speck32_serial_enc.sv
module speck32_serial_enc
    import speck_pkg::*;
#(
    parameter int W       = speck_pkg::WORD,
    parameter int A       = speck_pkg::ROT_R,
    parameter int B       = speck_pkg::ROT_L,
    parameter int ROUNDS  = speck_pkg::ROUNDS,
    parameter int M       = speck_pkg::KEY_WORDS,
    localparam int BW     = $clog2(W),
    localparam int RW     = $clog2(ROUNDS)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           start,
    input  logic [2*W-1:0] plaintext,
    input  logic [M*W-1:0] key,
    output logic [2*W-1:0] ciphertext,
    output logic           done
);
    ctl_state_t    st_q, st_n;
    logic          accept, running;
    logic [BW-1:0] bit_idx;
    logic [RW-1:0] rnd;
    logic          word_end, last_round;
    logic          rk_bit;
    logic [W-1:0]  dx_word, dy_word, dx_next;

    // next-state logic
    always_comb begin
        st_n = st_q;
        unique case (st_q)
            ST_IDLE: if (start) st_n = ST_RUN;
            ST_RUN:  if (word_end && last_round) st_n = ST_FIN;
            ST_FIN:  st_n = ST_IDLE;
            default: st_n = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_n;
    end

    assign accept  = (st_q == ST_IDLE) && start;
    assign running = (st_q == ST_RUN);

    // output register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            done       <= 1'b0;
            ciphertext <= '0;
        end else begin
            done <= (st_q == ST_FIN);
            if (st_q == ST_FIN) ciphertext <= {dx_word, dy_word};
        end
    end

    round_timer #(.W(W), .ROUNDS(ROUNDS)) u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear      (accept),
        .en         (running),
        .bit_idx    (bit_idx),
        .rnd        (rnd),
        .word_end   (word_end),
        .last_round (last_round)
    );

    speck_key_sched #(.W(W), .A(A), .B(B), .M(M), .ROUNDS(ROUNDS)) u_ksched (
        .clk      (clk),
        .rst_n    (rst_n),
        .ld       (accept),
        .key      (key),
        .en       (running),
        .bit_idx  (bit_idx),
        .rnd      (rnd),
        .word_end (word_end),
        .rk_bit   (rk_bit)
    );

    arx_serial_lane #(.W(W), .A(A), .B(B)) u_data (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (running),
        .bit_idx  (bit_idx),
        .kbit     (rk_bit),
        .ld_x     (accept),
        .ld_x_val (plaintext[2*W-1:W]),
        .ld_y     (accept),
        .ld_y_val (plaintext[W-1:0]),
        .y_bit    (),
        .x_word   (dx_word),
        .y_word   (dy_word),
        .x_next   (dx_next)
    );

    // R7: done never lasts two cycles
    assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R7: the ciphertext only moves together with done
    assert_ct_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (ciphertext != $past(ciphertext)) |-> done);

    // R5: a run is not interrupted by start before its last bit
    assert_busy_ignore_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (running && !(word_end && last_round)) |=> (st_q == ST_RUN));

    // R4: the last bit of the last round leads to the finish state, then to done
    assert_finish_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (running && word_end && last_round) |=> (st_q == ST_FIN && !done));

    // R4: done follows the finish state by one edge
    assert_done_after_fin_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_FIN) |=> done);
endmodule

// File: tb/sim_speck32_serial_enc.sv
module sim_speck32_serial_enc;
    localparam int CLK_PERIOD = 10;
    localparam int LAT        = 353;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [31:0] plaintext = '0;
    logic [63:0] key = '0;
    logic [31:0] ciphertext;
    logic        done;

    int checks = 0;
    int failures = 0;
    int cyc = 0;

    speck32_serial_enc u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .plaintext  (plaintext),
        .key        (key),
        .ciphertext (ciphertext),
        .done       (done)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            failures++;
            checks++;
            $display("FAIL WDOG run did not end actual=%0d expected<150000", cyc);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    function automatic logic [31:0] ref_enc(input logic [31:0] p, input logic [63:0] k);
        logic [15:0] x, y, kw, nl, l0, l1, l2;
        x = p[31:16]; y = p[15:0];
        kw = k[15:0]; l0 = k[31:16]; l1 = k[47:32]; l2 = k[63:48];
        for (int i = 0; i < 22; i++) begin
            x  = ({x[6:0], x[15:7]} + y) ^ kw;
            y  = {y[13:0], y[15:14]} ^ x;
            nl = ({l0[6:0], l0[15:7]} + kw) ^ 16'(i);
            kw = {kw[13:0], kw[15:14]} ^ nl;
            l0 = l1; l1 = l2; l2 = nl;
        end
        return {x, y};
    endfunction

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // mode 0: plain; 1: start pulses while busy; 2: inputs changed mid-run
    task automatic run_block(input logic [31:0] p, input logic [63:0] k, input int mode,
                             output logic [31:0] c, output int lat);
        @(negedge clk);
        plaintext = p; key = k; start = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
        lat = 0;
        for (int n = 1; n <= 1000; n++) begin
            @(posedge clk);
            @(negedge clk);
            lat = n;
            if (done) break;
            if (mode == 1 && n == 100) begin start = 1'b1; plaintext = ~p; key = ~k; end
            if (mode == 1 && n == 110) start = 1'b0;
            if (mode == 1 && n == 352) start = 1'b1;
            if (mode == 2 && n == 50)  begin plaintext = p ^ 32'h0f0f_1234; key = {k[31:0], k[63:32]}; end
        end
        start = 1'b0;
        c = ciphertext;
    endtask

    task automatic t_reset;
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1 done in reset", 64'(done), 64'd0);
        chk("R1 ct in reset", 64'(ciphertext), 64'd0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk("R1 done after reset", 64'(done), 64'd0);
        chk("R1 ct after reset", 64'(ciphertext), 64'd0);
    endtask

    task automatic t_vector;
        logic [31:0] c; int lat;
        run_block(32'h6574_694c, 64'h1918_1110_0908_0100, 0, c, lat);
        chk("R2 published vector", 64'(c), 64'h0000_0000_a868_42f2);
        chk("R4 latency", 64'(lat), 64'(LAT));
        @(negedge clk);
        chk("R7 done one cycle", 64'(done), 64'd0);
    endtask

    task automatic t_patterns;
        logic [31:0] c; int lat;
        logic [31:0] pv [4] = '{32'h0000_0000, 32'h1234_abcd, 32'h8000_0001, 32'hdead_beef};
        logic [63:0] kv [4] = '{64'h0, 64'h0f1e_2d3c_4b5a_6978, 64'h0123_4567_89ab_cdef, 64'hffff_0000_ffff_0000};
        for (int i = 0; i < 4; i++) begin
            run_block(pv[i], kv[i], 0, c, lat);
            chk("R3 vector", 64'(c), 64'(ref_enc(pv[i], kv[i])));
        end
    endtask

    task automatic t_carry;
        logic [31:0] c; int lat;
        run_block(32'hffff_ffff, 64'hffff_ffff_ffff_ffff, 0, c, lat);
        chk("R9 all ones", 64'(c), 64'(ref_enc(32'hffff_ffff, 64'hffff_ffff_ffff_ffff)));
        run_block(32'h7fff_ffff, 64'hfffe_ffff_7fff_8001, 0, c, lat);
        chk("R9 carry chain", 64'(c), 64'(ref_enc(32'h7fff_ffff, 64'hfffe_ffff_7fff_8001)));
    endtask

    task automatic t_busy_start;
        logic [31:0] c; int lat; int extra;
        run_block(32'h3c3c_a5a5, 64'h5555_aaaa_1357_9bdf, 1, c, lat);
        chk("R5 busy result", 64'(c), 64'(ref_enc(32'h3c3c_a5a5, 64'h5555_aaaa_1357_9bdf)));
        chk("R5 busy latency", 64'(lat), 64'(LAT));
        extra = 0;
        for (int n = 0; n < 400; n++) begin
            @(negedge clk);
            if (done) extra++;
        end
        chk("R5 no extra block", 64'(extra), 64'd0);
    endtask

    task automatic t_input_change;
        logic [31:0] c; int lat;
        run_block(32'h0bad_f00d, 64'h2468_ace0_1357_9bdf, 2, c, lat);
        chk("R6 inputs sampled once", 64'(c), 64'(ref_enc(32'h0bad_f00d, 64'h2468_ace0_1357_9bdf)));
    endtask

    task automatic t_hold;
        logic [31:0] c0; int bad;
        c0 = ciphertext;
        bad = 0;
        plaintext = 32'h1111_2222; key = 64'h9999;
        for (int n = 0; n < 60; n++) begin
            @(negedge clk);
            if (ciphertext !== c0 || done) bad++;
        end
        chk("R7 ct held while idle", 64'(bad), 64'd0);
    endtask

    task automatic t_back_to_back;
        logic [31:0] p1, p2, c1; logic [63:0] k1; int lat;
        p1 = 32'h4444_7777; p2 = 32'h9abc_0123; k1 = 64'h0f0f_f0f0_3333_cccc;
        @(negedge clk);
        plaintext = p1; key = k1; start = 1'b1;
        @(posedge clk);
        lat = 0;
        c1 = '0;
        for (int n = 1; n <= 1000; n++) begin
            @(posedge clk);
            @(negedge clk);
            lat = n;
            if (done && n == LAT) begin c1 = ciphertext; plaintext = p2; end
            else if (done) break;
        end
        start = 1'b0;
        chk("R8 first result", 64'(c1), 64'(ref_enc(p1, k1)));
        chk("R8 second latency", 64'(lat), 64'(2 * LAT + 1));
        chk("R8 second result", 64'(ciphertext), 64'(ref_enc(p2, k1)));
    endtask

    initial begin
        t_reset();
        t_vector();
        t_patterns();
        t_carry();
        t_busy_start();
        t_input_change();
        t_hold();
        t_back_to_back();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule